// File: doc/BRIEF.md
# SCSI Transfer Counter Unit

This unit owns the byte counter that paces a DMA transfer inside a SCSI protocol controller. Software programs a 24-bit start count one byte at a time over a byte-wide register bus, and writes a command. When the command carries the DMA flag, the working counter is loaded from the start count and the unit enters DMA mode. The datapath then reports each completed burst with a length, and the unit subtracts it. When the counter empties, a terminal-count flag is raised for the sequencer and for software.

Two behaviours depend on an extended-feature enable held in configuration register 2. A start count of zero means 64 KiB (0x10000) when the enable is clear and 16 MiB (0x1000000) when it is set, so the working counter is 25 bits wide. While the enable is set, a read of the high count byte returns a fixed chip identifier (0x12) in place of the counter byte.

Register map on `reg_addr`: 0, 1 and 2 are the count bytes (bits 7:0, 15:8 and 23:16). 3 is the command register, with the DMA flag at bit 7. 4 is configuration register 2, with the extended-feature enable at bit 6. A write to 0, 1 or 2 sets a start-count byte. A read of 0, 1 or 2 returns a byte of the working counter. Reads of 3 and 4 return the stored register, and other addresses read zero.

Top module: `xfer_count_unit`

## Requirements
- R1: A synchronous active-low reset clears the start count, the working count, the terminal-count flag, DMA mode, the command register and configuration register 2.
- R2: While bit 6 of configuration register 2 is clear, reads of addresses 0, 1 and 2 return bits 7:0, 15:8 and 23:16 of the working count.
- R3: A write to address 0, 1 or 2 sets that byte of the start count, clears the terminal-count flag and leaves the working count unchanged.
- R4: A write to address 3 with bit 7 set loads the working count from a nonzero start count and sets DMA mode. A write to address 3 with bit 7 clear clears DMA mode and leaves the count unchanged.
- R5: A reload from a zero start count loads 0x10000 while bit 6 of configuration register 2 is clear.
- R6: A reload from a zero start count loads 0x1000000 while bit 6 of configuration register 2 is set. Address 4 reads back what was written to it.
- R7: In DMA mode, a decrement subtracts `dec_len` from the count one cycle later, and the result saturates at zero.
- R8: The terminal-count flag is set when a decrement takes the count from nonzero to zero. A decrement applied to a count that is already zero does not set it.
- R9: A read of address 2 returns 0x12 while bit 6 of configuration register 2 is set, and the stored high byte otherwise. The enable does not change the count.
- R10: A decrement request while DMA mode is off leaves the count unchanged.
- R11: When a decrement empties the count in the same cycle as a count-register write, the terminal-count flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| dec_valid | input | 1 | Decrement request from the DMA datapath |
| dec_len | input | 25 | Bytes moved by this request |
| count | output | 25 | Working transfer count |
| tc | output | 1 | Terminal-count flag |
| dma_mode | output | 1 | DMA mode from the last command |

## Verification
A wrong working count shows on `count` one cycle after the reload or decrement that produced it, and it shows on the byte reads at once. A wrong terminal-count state shows on `tc` in the cycle after the decrement that emptied the counter, or after the count-register write that should have cleared it. A stale configuration bit does not show on `count` until the next zero-count reload. It does show at once in the high-byte read, so the bench reads that byte after every change to the enable.

// File: rtl/xcu_pkg.sv
package xcu_pkg;
    // Shared widths and the register address map of the transfer counter unit.
    localparam int BYTE_W      = 8;
    localparam int N_CNT_BYTES = 3;
    localparam int CNT_W       = BYTE_W * N_CNT_BYTES;
    localparam int ADDR_W      = 3;
    localparam int DMA_BIT     = 7;
    localparam int EXT_BIT     = 6;
    localparam int LEGACY_W    = 16;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CNT_LO  = 3'd0,
        ADR_CNT_MID = 3'd1,
        ADR_CNT_HI  = 3'd2,
        ADR_CMD     = 3'd3,
        ADR_CFG2    = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/xcu_start_regs.sv
// Start-count byte registers.
// Holds N_BYTES software-written bytes that form the reload value.
// Assumes that byte i lives at address i and that one write happens per cycle.
module xcu_start_regs #(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 3,
    parameter int ADDR_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [BYTE_W-1:0]         wdata,
    output logic [N_BYTES*BYTE_W-1:0] start_cnt,
    output logic                      cnt_wr
);
    // A write to any count-byte address.
    assign cnt_wr = wr && (int'(addr) < N_BYTES);

    for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;
        // Capture the byte addressed by this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (wr && (int'(addr) == i))
                byte_q <= wdata;
        end
        assign start_cnt[i*BYTE_W +: BYTE_W] = byte_q;
    end
endmodule

// File: rtl/xcu_ctrl_regs.sv
// Command and configuration registers.
// Tracks DMA mode, produces a one-cycle reload request and holds the extended-feature enable.
// Assumes that command writes are single-cycle strobes.
module xcu_ctrl_regs #(
    parameter int BYTE_W  = 8,
    parameter int ADDR_W  = 3,
    parameter int DMA_BIT = 7,
    parameter int EXT_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [BYTE_W-1:0] cfg2_q,
    output logic              dma_mode,
    output logic              reload,
    output logic              ext_en
);
    import xcu_pkg::*;

    logic cmd_wr;
    assign cmd_wr = wr && (addr == ADR_CMD);
    assign reload = cmd_wr && wdata[DMA_BIT];
    assign ext_en = cfg2_q[EXT_BIT];

    // Store the last command and follow its DMA flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            dma_mode <= 1'b0;
        end else if (cmd_wr) begin
            cmd_q    <= wdata;
            dma_mode <= wdata[DMA_BIT];
        end
    end

    // Store configuration register 2.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg2_q <= '0;
        else if (wr && (addr == ADR_CFG2))
            cfg2_q <= wdata;
    end
endmodule

// File: rtl/xcu_work_counter.sv
// Working transfer counter with terminal-count flag.
// Reloads from the start count (a zero start count means 2**LEGACY_W, or 2**CNT_W with
// the extended feature), subtracts decrement lengths with saturation at zero, and sets
// the flag on a nonzero-to-zero move. Reload has priority over decrement, and setting
// the flag has priority over clearing it.
module xcu_work_counter #(
    parameter int CNT_W    = 24,
    parameter int LEGACY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic             ext_en,
    input  logic             dec_en,
    input  logic [CNT_W:0]   dec_len,
    input  logic             clr_tc,
    output logic [CNT_W:0]   count,
    output logic             tc
);
    localparam logic [CNT_W:0] FULL_EXT = (CNT_W+1)'(1) << CNT_W;
    localparam logic [CNT_W:0] FULL_LEG = (CNT_W+1)'(1) << LEGACY_W;

    logic [CNT_W:0] reload_val;
    logic [CNT_W:0] dec_amt;
    logic [CNT_W:0] dec_next;
    logic           set_tc;

    // Choose the reload value, expanding a zero start count.
    always_comb begin
        if (start_cnt == '0)
            reload_val = ext_en ? FULL_EXT : FULL_LEG;
        else
            reload_val = {1'b0, start_cnt};
    end

    // Clamp the decrement to the current count so that the result never wraps.
    always_comb begin
        dec_amt  = (dec_len > count) ? count : dec_len;
        dec_next = count - dec_amt;
        set_tc   = dec_en && !reload && (count != '0) && (dec_next == '0);
    end

    // Update the working count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (reload)
            count <= reload_val;
        else if (dec_en)
            count <= dec_next;
    end

    // Keep the terminal-count flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tc <= 1'b0;
        else if (set_tc)
            tc <= 1'b1;
        else if (clr_tc)
            tc <= 1'b0;
    end
endmodule

// File: rtl/xcu_read_mux.sv
// Register read multiplexer.
// Returns working-count bytes, the command and config registers, and the chip
// identifier in place of the top count byte while the extended feature is enabled.
module xcu_read_mux #(
    parameter int          BYTE_W  = 8,
    parameter int          N_BYTES = 3,
    parameter int          ADDR_W  = 3,
    parameter logic [7:0]  CHIP_ID = 8'h12
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [N_BYTES*BYTE_W:0]     count,
    input  logic [BYTE_W-1:0]           cmd_q,
    input  logic [BYTE_W-1:0]           cfg2_q,
    input  logic                        ext_en,
    output logic [BYTE_W-1:0]           rdata
);
    import xcu_pkg::*;

    // Select the read byte for the current address.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_BYTES; i++) begin
            if (int'(addr) == i) begin
                if ((i == N_BYTES-1) && ext_en)
                    rdata = BYTE_W'(CHIP_ID);
                else
                    rdata = count[i*BYTE_W +: BYTE_W];
            end
        end
        if (addr == ADR_CMD)  rdata = cmd_q;
        if (addr == ADR_CFG2) rdata = cfg2_q;
    end
endmodule

// File: rtl/xfer_count_unit.sv
// Transfer counter unit top.
// Joins the start-count registers, the control registers, the working counter and the
// read multiplexer. Assumes one register write per cycle and a byte-wide bus.
module xfer_count_unit #(
    parameter logic [7:0] CHIP_ID = 8'h12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [xcu_pkg::ADDR_W-1:0] reg_addr,
    input  logic [xcu_pkg::BYTE_W-1:0] reg_wdata,
    output logic [xcu_pkg::BYTE_W-1:0] reg_rdata,
    input  logic                       dec_valid,
    input  logic [xcu_pkg::CNT_W:0]    dec_len,
    output logic [xcu_pkg::CNT_W:0]    count,
    output logic                       tc,
    output logic                       dma_mode
);
    import xcu_pkg::*;

    logic [CNT_W-1:0]  start_cnt;
    logic              cnt_wr;
    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] cfg2_q;
    logic              reload;
    logic              ext_en;

    xcu_start_regs #(.BYTE_W(BYTE_W), .N_BYTES(N_CNT_BYTES), .ADDR_W(ADDR_W)) u_start (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .start_cnt(start_cnt), .cnt_wr(cnt_wr)
    );

    xcu_ctrl_regs #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .DMA_BIT(DMA_BIT), .EXT_BIT(EXT_BIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cmd_q(cmd_q), .cfg2_q(cfg2_q), .dma_mode(dma_mode), .reload(reload), .ext_en(ext_en)
    );

    xcu_work_counter #(.CNT_W(CNT_W), .LEGACY_W(LEGACY_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .reload(reload), .start_cnt(start_cnt), .ext_en(ext_en),
        .dec_en(dec_valid && dma_mode), .dec_len(dec_len), .clr_tc(cnt_wr),
        .count(count), .tc(tc)
    );

    xcu_read_mux #(.BYTE_W(BYTE_W), .N_BYTES(N_CNT_BYTES), .ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID)) u_rd (
        .addr(reg_addr), .count(count), .cmd_q(cmd_q), .cfg2_q(cfg2_q), .ext_en(ext_en),
        .rdata(reg_rdata)
    );
endmodule

// File: rtl/xfer_count_chk.sv
// Checker for the transfer counter unit, bound to the top.
// Relates the port behaviour to the start count and the feature enable over time.
module xfer_count_chk #(
    parameter int         CNT_W   = 24,
    parameter logic [7:0] CHIP_ID = 8'h12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic             dec_valid,
    input logic [CNT_W:0]   dec_len,
    input logic [CNT_W:0]   count,
    input logic             tc,
    input logic             dma_mode,
    input logic [CNT_W-1:0] start_cnt,
    input logic             ext_en
);
    logic cmd_wr, cnt_wr, empties;
    assign cmd_wr  = reg_wr && (reg_addr == 3'd3);
    assign cnt_wr  = reg_wr && (reg_addr < 3'd3);
    assign empties = dec_valid && dma_mode && (count != '0) && (dec_len >= count);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !tc && !dma_mode));

    assert_cnt_wr_clears_tc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr && !empties |=> !tc);

    assert_cnt_wr_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr && !dec_valid |=> $stable(count));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && reg_wdata[7] && (start_cnt != '0) |=> (count == {1'b0, $past(start_cnt)}) && dma_mode);

    assert_zero_legacy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && reg_wdata[7] && (start_cnt == '0) && !ext_en |=> count == (CNT_W+1)'(32'h10000));

    assert_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && reg_wdata[7] && (start_cnt == '0) && ext_en |=> count == ((CNT_W+1)'(1) << CNT_W));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= ((CNT_W+1)'(1) << CNT_W));

    assert_tc_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc) |-> ($past(count) != '0) && (count == '0));

    assert_chip_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_en && (reg_addr == 3'd2) |-> reg_rdata == CHIP_ID);

    assert_dma_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode && !cmd_wr |=> $stable(count));

    assert_tc_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        empties && !cmd_wr |=> tc);
endmodule

bind xfer_count_unit xfer_count_chk #(.CNT_W(xcu_pkg::CNT_W), .CHIP_ID(CHIP_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dec_valid(dec_valid), .dec_len(dec_len), .count(count), .tc(tc),
    .dma_mode(dma_mode), .start_cnt(start_cnt), .ext_en(ext_en)
);

// File: tb/test_xfer_count_unit.sv
module test_xfer_count_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        dec_valid = 1'b0;
    logic [24:0] dec_len = '0;
    logic [24:0] count;
    logic        tc;
    logic        dma_mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xfer_count_unit i_xfer_count_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dec_valid(dec_valid), .dec_len(dec_len), .count(count),
        .tc(tc), .dma_mode(dma_mode)
    );

    localparam logic [2:0] OP_WR = 3'd0, OP_DEC = 3'd1, OP_CNT = 3'd2, OP_TC = 3'd3,
                           OP_RD = 3'd4, OP_DMA = 3'd5;
    localparam int NV = 46;
    // Entry: {op, addr, value, requirement number}.
    localparam logic [34:0] VEC [0:NV-1] = '{
        {OP_WR, 3'd0, 25'h34, 4'd3}, {OP_WR, 3'd1, 25'h12, 4'd3}, {OP_WR, 3'd2, 25'h00, 4'd3},
        {OP_WR, 3'd3, 25'h80, 4'd4},
        {OP_CNT, 3'd0, 25'h1234, 4'd4},   // R4 reload
        {OP_DMA, 3'd0, 25'h1, 4'd4},      // R4 DMA mode on
        {OP_RD, 3'd0, 25'h34, 4'd2},      // R2 low byte
        {OP_RD, 3'd1, 25'h12, 4'd2},      // R2 middle byte
        {OP_RD, 3'd2, 25'h00, 4'd2},      // R2 high byte
        {OP_DEC, 3'd0, 25'h34, 4'd7},
        {OP_CNT, 3'd0, 25'h1200, 4'd7},   // R7 subtract
        {OP_TC, 3'd0, 25'h0, 4'd8},       // R8 not yet empty
        {OP_DEC, 3'd0, 25'h1200, 4'd7},
        {OP_CNT, 3'd0, 25'h0, 4'd7},      // R7 exact empty
        {OP_TC, 3'd0, 25'h1, 4'd8},       // R8 set
        {OP_WR, 3'd0, 25'h05, 4'd3},
        {OP_TC, 3'd0, 25'h0, 4'd3},       // R3 clears flag
        {OP_CNT, 3'd0, 25'h0, 4'd3},      // R3 count untouched
        {OP_DEC, 3'd0, 25'h3, 4'd7},
        {OP_CNT, 3'd0, 25'h0, 4'd7},      // R7 saturate at zero
        {OP_TC, 3'd0, 25'h0, 4'd8},       // R8 no set from zero
        {OP_WR, 3'd3, 25'h80, 4'd4},
        {OP_CNT, 3'd0, 25'h1205, 4'd4},   // R4 reload new start
        {OP_DEC, 3'd0, 25'h2000, 4'd7},
        {OP_CNT, 3'd0, 25'h0, 4'd7},      // R7 oversize clamps
        {OP_TC, 3'd0, 25'h1, 4'd8},       // R8 set by clamp
        {OP_WR, 3'd3, 25'h80, 4'd4}, {OP_WR, 3'd3, 25'h01, 4'd4},
        {OP_DMA, 3'd0, 25'h0, 4'd4},      // R4 DMA off
        {OP_CNT, 3'd0, 25'h1205, 4'd4},   // R4 count kept
        {OP_DEC, 3'd0, 25'h5, 4'd10},
        {OP_CNT, 3'd0, 25'h1205, 4'd10},  // R10 ignored
        {OP_WR, 3'd0, 25'h00, 4'd5}, {OP_WR, 3'd1, 25'h00, 4'd5}, {OP_WR, 3'd3, 25'h80, 4'd5},
        {OP_CNT, 3'd0, 25'h10000, 4'd5},  // R5 legacy zero
        {OP_RD, 3'd2, 25'h01, 4'd2},      // R2 high byte of 0x10000
        {OP_WR, 3'd4, 25'h40, 4'd6},
        {OP_RD, 3'd4, 25'h40, 4'd6},      // R6 config readback
        {OP_WR, 3'd3, 25'h80, 4'd6},
        {OP_CNT, 3'd0, 25'h1000000, 4'd6},// R6 extended zero
        {OP_RD, 3'd2, 25'h12, 4'd9},      // R9 chip id
        {OP_DEC, 3'd0, 25'h1000000, 4'd7},
        {OP_CNT, 3'd0, 25'h0, 4'd7},      // R7 full drain
        {OP_TC, 3'd0, 25'h1, 4'd8},       // R8 set
        {OP_WR, 3'd4, 25'h00, 4'd9}
    };

    task automatic check(input int req, input logic [24:0] act, input logic [24:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic dec(input logic [24:0] l);
        @(negedge clk);
        dec_valid = 1'b1; dec_len = l;
        @(negedge clk);
        dec_valid = 1'b0;
    endtask

    task automatic rd_chk(input int req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, {17'd0, reg_rdata}, {17'd0, exp});
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(1, count, 25'h0);
        check(1, {24'd0, tc}, 25'h0);
        check(1, {24'd0, dma_mode}, 25'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [2:0]  a;
            logic [24:0] v;
            int          rq;
            op = VEC[i][34:32]; a = VEC[i][31:29]; v = VEC[i][28:4]; rq = int'(VEC[i][3:0]);
            case (op)
                OP_WR:  wr_reg(a, v[7:0]);
                OP_DEC: dec(v);
                OP_CNT: check(rq, count, v);
                OP_TC:  check(rq, {24'd0, tc}, v);
                OP_DMA: check(rq, {24'd0, dma_mode}, v);
                default: rd_chk(rq, a, v[7:0]);
            endcase
        end

        // R9 stored high byte versus chip id
        wr_reg(3'd2, 8'hAB); wr_reg(3'd0, 8'h01); wr_reg(3'd3, 8'h80);
        rd_chk(9, 3'd2, 8'hAB);
        rd_chk(2, 3'd0, 8'h01);
        wr_reg(3'd4, 8'h40);
        rd_chk(9, 3'd2, 8'h12);
        check(9, count, 25'hAB0001);

        // R11 emptying decrement and count write in one cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h00;
        dec_valid = 1'b1; dec_len = 25'hAB0001;
        @(negedge clk);
        reg_wr = 1'b0; dec_valid = 1'b0;
        check(11, {24'd0, tc}, 25'h1);
        check(11, count, 25'h0);

        // R1 reset clears everything, including the start count and the config register
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(1, count, 25'h0);
        check(1, {24'd0, tc}, 25'h0);
        check(1, {24'd0, dma_mode}, 25'h0);
        rd_chk(1, 3'd4, 8'h00);
        rd_chk(1, 3'd3, 8'h00);
        wr_reg(3'd3, 8'h80);
        check(1, count, 25'h10000);

        finish_run();
    end
endmodule